// File: doc/BRIEF.md
# Pairwise Oscillator Synchronization Readout

This block reads out the state of a small network of four coupled oscillators whose outputs have already been squared up into logic levels and brought into the local clock domain. A start pulse launches one measurement. The block first lets a settling interval go by, with all oscillator activity ignored. It then watches every one of the six unordered oscillator pairs in parallel over one evaluation window, and ends the run by latching a six-bit mask that marks the pairs judged quasi-synchronized.

Each pair detector works in one of two modes, chosen at start. The difference mode keeps a signed tally of rising edges, one up and one down, and scores the magnitude of the result. The alternation mode counts the times one signal shows two rising edges in a row with no edge of its partner between them. A pair is reported as synchronized when its score is strictly below a threshold. The threshold is not set by hand; it is derived from the window length and the clock rate so that the allowed score per microsecond stays fixed at twelve.

Top module: `osc_sync_readout`

## Requirements
- R1: After reset, syncMask is 0, done is 0 and busy is 0.
- R2: A start pulse sampled while idle raises busy at the next edge; counting the edge that samples start as edge 1, done is high for the period after edge SETTLE_CYC+WINDOW_CYC+3, and busy falls at that same edge.
- R3: Rising edges seen during the first SETTLE_CYC cycles of a run, the settling interval, do not contribute to any score.
- R4: With mode = 0 at start, a pair's score is the magnitude of (rising edges of the lower-numbered oscillator) minus (rising edges of the higher-numbered one) over the WINDOW_CYC-cycle window.
- R5: With mode = 1 at start, a pair's score counts each rising edge of one oscillator whose previous edge in the window, within that pair, came from the same oscillator; coinciding edges on both add nothing and clear the memory of the last source.
- R6: The threshold is floor(WINDOW_CYC*RATE_PER_US/CYC_PER_US), 6 by default; a pair bit is 1 only when its score is strictly below it, so a score of 5 sets the bit and a score of 6 does not.
- R7: syncMask bits 0 to 5 stand for oscillator pairs (0,1),(0,2),(0,3),(1,2),(1,3),(2,3), oscillators numbered by osc bit index.
- R8: syncMask keeps its value through a run and takes the new result one clock before done is high.
- R9: done is high for exactly one clock per completed run.
- R10: A start pulse while busy is ignored: the run in progress keeps its timing and no extra run follows.
- R11: mode is sampled only with the accepted start; changing it during a run does not change the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a measurement run when idle |
| mode | input | 1 | Detector choice: 0 edge difference, 1 alternation |
| osc | input | 4 | Digitized oscillator levels, one bit per oscillator |
| syncMask | output | 6 | Pairs judged synchronized in the last completed run |
| done | output | 1 | One-clock pulse marking a new result |
| busy | output | 1 | High while a run is in progress |

## Verification
The hardest condition to reach from the pins is one where the two detector modes disagree: periodic square waves with equal rates give the same verdict in both. The bench drives one oscillator with a burst waveform, two edges close together and then a long gap, at the same average rate as its partners, so the difference score is zero while the alternation score is well over the threshold. Exact scores of 5 and 6 for the threshold boundary come from periods that divide the window evenly, which makes the edge counts independent of where the window falls.

// File: rtl/osc_sync_pkg.sv
`timescale 1ns/1ps
package osc_sync_pkg;

  localparam int NUM_OSC  = 4;
  localparam int NUM_PAIR = NUM_OSC * (NUM_OSC - 1) / 2;

  typedef struct packed {
    logic clearAcc;
    logic evalEn;
    logic latchMask;
    logic altMode;
  } ctrl_strobe_t;

  // Lower-numbered oscillator of pair index p, pairs enumerated i<j ascending.
  function automatic int pairFirst(input int p);
    int k;
    k = 0;
    for (int i = 0; i < NUM_OSC; i++)
      for (int j = i + 1; j < NUM_OSC; j++) begin
        if (k == p) return i;
        k++;
      end
    return 0;
  endfunction

  function automatic int pairSecond(input int p);
    int k;
    k = 0;
    for (int i = 0; i < NUM_OSC; i++)
      for (int j = i + 1; j < NUM_OSC; j++) begin
        if (k == p) return j;
        k++;
      end
    return 1;
  endfunction

endpackage

// File: rtl/osc_sync_ctrl.sv
`timescale 1ns/1ps
module osc_sync_ctrl
  import osc_sync_pkg::*;
#(
  parameter int SETTLE_CYC = 100,
  parameter int WINDOW_CYC = 100
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         mode,
  output ctrl_strobe_t strb,
  output logic         busy,
  output logic         done
);
  localparam int MAX_CYC = (SETTLE_CYC > WINDOW_CYC) ? SETTLE_CYC : WINDOW_CYC;
  localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] WINDOW_LAST = CNT_W'(WINDOW_CYC - 1);
  localparam logic [CNT_W-1:0] CNT_ONE     = 1;

  typedef enum logic [2:0] {ST_IDLE, ST_SETTLE, ST_EVAL, ST_LATCH, ST_REPORT} state_t;

  state_t           state;
  logic [CNT_W-1:0] phaseCnt;
  logic             modeQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
      modeQ    <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= (state == ST_REPORT);
      case (state)
        ST_IDLE: if (start) begin
          state    <= ST_SETTLE;
          phaseCnt <= '0;
          modeQ    <= mode;
        end
        ST_SETTLE: if (phaseCnt == SETTLE_LAST) begin
          state    <= ST_EVAL;
          phaseCnt <= '0;
        end else begin
          phaseCnt <= phaseCnt + CNT_ONE;
        end
        ST_EVAL: if (phaseCnt == WINDOW_LAST) begin
          state    <= ST_LATCH;
          phaseCnt <= '0;
        end else begin
          phaseCnt <= phaseCnt + CNT_ONE;
        end
        ST_LATCH:  state <= ST_REPORT;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.clearAcc  = (state == ST_SETTLE);
    strb.evalEn    = (state == ST_EVAL);
    strb.latchMask = (state == ST_LATCH);
    strb.altMode   = modeQ;
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/osc_pair_detector.sv
`timescale 1ns/1ps
module osc_pair_detector
  import osc_sync_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_strobe_t     strb,
  input  logic             edgeA,
  input  logic             edgeB,
  output logic [CNT_W-1:0] score
);
  localparam logic [CNT_W:0]   DIFF_ONE = 1;
  localparam logic [CNT_W-1:0] ALT_ONE  = 1;

  typedef enum logic [1:0] {SRC_NONE, SRC_A, SRC_B} src_t;

  logic [CNT_W:0]   diffQ;   // two's complement tally, A up / B down
  logic [CNT_W-1:0] altCnt;
  src_t             lastSrc;
  logic [CNT_W:0]   diffMag;

  always_ff @(posedge clk) begin
    if (!rstN || strb.clearAcc) begin
      diffQ   <= '0;
      altCnt  <= '0;
      lastSrc <= SRC_NONE;
    end else if (strb.evalEn) begin
      if (edgeA && !edgeB)      diffQ <= diffQ + DIFF_ONE;
      else if (edgeB && !edgeA) diffQ <= diffQ - DIFF_ONE;

      if (edgeA && edgeB) begin
        lastSrc <= SRC_NONE;
      end else if (edgeA) begin
        if (lastSrc == SRC_A) altCnt <= altCnt + ALT_ONE;
        lastSrc <= SRC_A;
      end else if (edgeB) begin
        if (lastSrc == SRC_B) altCnt <= altCnt + ALT_ONE;
        lastSrc <= SRC_B;
      end
    end
  end

  always_comb begin
    diffMag = diffQ[CNT_W] ? ('0 - diffQ) : diffQ;
    score   = strb.altMode ? altCnt : diffMag[CNT_W-1:0];
  end

endmodule

// File: rtl/osc_sync_datapath.sv
`timescale 1ns/1ps
module osc_sync_datapath
  import osc_sync_pkg::*;
#(
  parameter int CNT_W  = 7,
  parameter int THRESH = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrl_strobe_t        strb,
  input  logic [NUM_OSC-1:0]  osc,
  output logic [NUM_PAIR-1:0] syncMask
);
  localparam logic [CNT_W:0] THRESH_W = (CNT_W+1)'(THRESH);

  logic [NUM_OSC-1:0]  oscQ;
  logic [NUM_OSC-1:0]  oscPrev;
  logic [NUM_OSC-1:0]  riseEdge;
  logic [NUM_PAIR-1:0] pairHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      oscQ    <= '0;
      oscPrev <= '0;
    end else begin
      oscQ    <= osc;
      oscPrev <= oscQ;
    end
  end

  assign riseEdge = oscQ & ~oscPrev;

  for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
    localparam int IDX_A = pairFirst(p);
    localparam int IDX_B = pairSecond(p);
    logic [CNT_W-1:0] pairScore;

    osc_pair_detector #(.CNT_W(CNT_W)) u_det (
      .clk   (clk),
      .rstN  (rstN),
      .strb  (strb),
      .edgeA (riseEdge[IDX_A]),
      .edgeB (riseEdge[IDX_B]),
      .score (pairScore)
    );

    assign pairHit[p] = ({1'b0, pairScore} < THRESH_W);
  end

  always_ff @(posedge clk) begin
    if (!rstN)               syncMask <= '0;
    else if (strb.latchMask) syncMask <= pairHit;
  end

endmodule

// File: rtl/osc_sync_readout.sv
`timescale 1ns/1ps
module osc_sync_readout
  import osc_sync_pkg::*;
#(
  parameter int SETTLE_CYC  = 100,
  parameter int WINDOW_CYC  = 100,
  parameter int CYC_PER_US  = 200,
  parameter int RATE_PER_US = 12
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       mode,
  input  logic [3:0] osc,
  output logic [5:0] syncMask,
  output logic       done,
  output logic       busy
);
  localparam int CNT_W  = $clog2(WINDOW_CYC + 1);
  localparam int THRESH = (WINDOW_CYC * RATE_PER_US) / CYC_PER_US;

  ctrl_strobe_t strb;

  osc_sync_ctrl #(.SETTLE_CYC(SETTLE_CYC), .WINDOW_CYC(WINDOW_CYC)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .mode  (mode),
    .strb  (strb),
    .busy  (busy),
    .done  (done)
  );

  osc_sync_datapath #(.CNT_W(CNT_W), .THRESH(THRESH)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .osc      (osc),
    .syncMask (syncMask)
  );

endmodule

// File: rtl/osc_sync_checker.sv
`timescale 1ns/1ps
module osc_sync_checker (
  input logic       clk,
  input logic       rstN,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic [5:0] syncMask
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9
  AST_MASK_THEN_DONE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(syncMask) |=> done); // R8
  AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done); // R2
  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy); // R2
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R10
endmodule

bind osc_sync_readout osc_sync_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .syncMask (syncMask)
);

// File: tb/osc_sync_readout_tb.sv
`timescale 1ns/1ps
module osc_sync_readout_tb;
  localparam int SETTLE = 100;
  localparam int WINDOW = 100;
  localparam int RUN_N  = SETTLE + WINDOW + 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic       mode = 1'b0;
  logic [3:0] osc = '0;
  logic [5:0] syncMask;
  logic       done;
  logic       busy;

  int nChecks = 0;
  int nFails  = 0;
  int tick    = 0;
  int period [4];
  int shift  [4];
  bit burst  [4];
  bit noisy  = 1'b0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  osc_sync_readout #(.SETTLE_CYC(SETTLE), .WINDOW_CYC(WINDOW),
                     .CYC_PER_US(200), .RATE_PER_US(12)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode), .osc(osc),
    .syncMask(syncMask), .done(done), .busy(busy)
  );

  function automatic logic oscLevel(int i, int t);
    int ph;
    ph = (t + shift[i]) % period[i];
    if (burst[i]) return (ph == 0) || (ph == 2);
    return ph < period[i] / 2;
  endfunction

  always @(negedge clk) begin
    tick <= tick + 1;
    for (int i = 0; i < 4; i++) osc[i] <= oscLevel(i, tick);
    if (noisy) osc[3] <= tick[0];
  end

  task automatic check(string rq, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
    end
  endtask

  task automatic setPattern(int p0, int s0, int p1, int s1, int p2, int s2,
                            int p3, int s3, bit b1);
    period = '{p0, p1, p2, p3};
    shift  = '{s0, s1, s2, s3};
    burst  = '{1'b0, b1, 1'b0, 1'b0};
  endtask

  // One run: checks timing, hold of old mask, pre-done update, pulse width.
  task automatic runOnce(bit m, logic [5:0] expMask, string rq,
                         int pokeAt, int flipAt, int noiseFor);
    logic [5:0] oldMask;
    logic [5:0] prevMask;
    int n;
    oldMask = syncMask;
    @(negedge clk); start = 1'b1; mode = m; noisy = (noiseFor > 0);
    @(negedge clk); start = 1'b0;
    n = 1;
    check("R2 busy after start", int'(busy), 1);
    prevMask = syncMask;
    while (!done && n < RUN_N + 50) begin
      prevMask = syncMask;
      @(negedge clk); n++;
      start = (n == pokeAt);
      if (n == flipAt) mode = ~m;
      if (n == noiseFor) noisy = 1'b0;
      if (n == 50) check("R8 mask held during run", int'(syncMask), int'(oldMask));
    end
    start = 1'b0; noisy = 1'b0;
    check("R2 done timing", n, RUN_N);
    check("R2 busy low at done", int'(busy), 0);
    check({rq, " mask"}, int'(syncMask), int'(expMask));
    check("R8 mask ready before done", int'(prevMask), int'(expMask));
    @(negedge clk);
    check("R9 done one cycle", int'(done), 0);
  endtask

  task automatic testReset();
    check("R1 mask reset", int'(syncMask), 0);
    check("R1 done reset", int'(done), 0);
    check("R1 busy reset", int'(busy), 0);
  endtask

  task automatic testDiffEqual();
    setPattern(10, 0, 10, 0, 10, 0, 10, 0, 1'b0);
    runOnce(1'b0, 6'h3F, "R4 R7 equal rates", 0, 0, 0);
  endtask

  task automatic testDiffMixed();
    // counts 10,10,12..13,4 -> pairs (0,1),(0,2),(1,2) pass
    setPattern(10, 0, 10, 5, 8, 0, 25, 0, 1'b0);
    runOnce(1'b0, 6'h0B, "R4 R7 mixed rates", 0, 0, 0);
  endtask

  task automatic testThreshold();
    setPattern(10, 0, 10, 0, 10, 0, 20, 0, 1'b0);   // score 5
    runOnce(1'b0, 6'h3F, "R6 score five passes", 0, 0, 0);
    setPattern(10, 0, 10, 0, 10, 0, 25, 0, 1'b0);   // score 6
    runOnce(1'b0, 6'h0B, "R6 score six fails", 0, 0, 0);
  endtask

  task automatic testSettleIgnored();
    setPattern(10, 0, 10, 0, 10, 0, 10, 0, 1'b0);
    runOnce(1'b0, 6'h3F, "R3 settle edges dropped", 0, 0, 60);
  endtask

  task automatic testAlternation();
    // osc1 bursts two edges per 20 cycles; same rate, no alternation
    setPattern(10, 0, 20, 15, 10, 0, 10, 0, 1'b1);
    runOnce(1'b1, 6'h26, "R5 R11 burst pattern", 0, SETTLE + 5, 0);
    setPattern(10, 0, 10, 0, 10, 0, 10, 0, 1'b0);
    runOnce(1'b1, 6'h3F, "R5 coinciding edges", 0, 0, 0);
  endtask

  task automatic testBusyStart();
    setPattern(10, 0, 10, 5, 8, 0, 25, 0, 1'b0);
    runOnce(1'b0, 6'h0B, "R10 start while busy", SETTLE + 20, 0, 0);
    begin
      int extra = 0;
      for (int k = 0; k < RUN_N + 20; k++) begin
        @(negedge clk);
        if (done || busy) extra++;
      end
      check("R10 no second run", extra, 0);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDiffEqual();
    testDiffMixed();
    testThreshold();
    testSettleIgnored();
    testAlternation();
    testBusyStart();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(150000 * 5);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule